// File: doc/BRIEF.md
# Debug Halt and Breakpoint Controller

This block decides when the execution unit of a small microsequenced timer coprocessor stops for debug. Breakpoint requests arrive from internal comparators, from software and the event input, from the error and single-step logic, and from an external debug source. The controller keeps each internal request pending and turns it into a registered halt at the next microcycle boundary. An external request halts only if a control bit enables it, and another bit picks the boundary for it: the end of the microcycle or the end of the whole instruction thread.

While halted, the block can freeze the timer-counter clock enable and stop input-pin sampling. It also drives an event-out status pin, and it qualifies channel-register write tracing. A resume input releases the halt. After a resume, the next boundary strobe is let through without a halt, so that the unit does not stop twice at the same instruction. A self-clearing clear command discards internal requests but leaves a live external request in place.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: The control register resets to 0. Bit 0 enables external halts, bit 1 selects the external halt boundary (1 = thread end), bit 2 mutes event-out, bit 4 stops the timer clock, bit 5 stops pin sampling and bit 6 disables channel-write tracing (active-low). Bits 3 and 7 always read 0.
- R2: Writing 1 to bit 3 produces a one-cycle clear pulse. One cycle after the write, the pulse discards every pending internal request and the reset flag.
- R3: An internal request (`bkpt_req` bit i) stays pending until cleared. While pending, the next `uc_end` strobe sets `halt` at that clock edge.
- R4: While bit 0 is 0, `ext_req` causes no halt and does not show on event-out.
- R5: With external halts enabled and `ext_req` high, the halt occurs on `uc_end` when bit 1 is 0 and only on `thr_end` when bit 1 is 1.
- R6: `resume` is refused while an enabled external request is present, and the clear command does not change this. Resume works again once `ext_req` falls or bit 0 is cleared.
- R7: After an accepted resume, the first boundary strobe (`uc_end` or `thr_end`) cannot set the halt.
- R8: Event-out is high when bit 2 is 0 and any of these holds: the reset flag is set, `dbg_req` is high, a pending request from sources 4 to 8 (illegal, software, event-in, misc error, single step) is present, or an enabled external request is present. Bit 2 set to 1 forces event-out low.
- R9: `tclk_en` is low exactly when halted with bit 4 set.
- R10: With bit 5 set, `pin_smp_en` is low during a forced instruction or when halted outside a single step. Pins are sampled during single steps and whenever bit 5 is 0.
- R11: `chw_trace_en` is high only when bit 6 is 0 and `prog_trace_on` is high.
- R12: After reset `halt` is 0, and event-out is high from the reset flag until a clear command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control register read data |
| bkpt_req | input | 9 | Internal request pulses: 0 data write, 1 channel write, 2 channel service, 3 address match, 4 illegal, 5 software, 6 event-in, 7 misc error, 8 single step |
| ext_req | input | 1 | External breakpoint request level |
| dbg_req | input | 1 | Debug request level, reported on event-out |
| uc_end | input | 1 | Microcycle end strobe |
| thr_end | input | 1 | Instruction thread end strobe |
| resume | input | 1 | Request to leave the halt |
| step_i | input | 1 | Single step in progress |
| forced_i | input | 1 | Forced instruction executing |
| prog_trace_on | input | 1 | Program trace enabled for serviced channel |
| halt | output | 1 | Registered halt to the execution unit |
| tclk_en | output | 1 | Timer counter clock enable |
| pin_smp_en | output | 1 | Input pin sample enable |
| evt_out | output | 1 | Event-out breakpoint status |
| chw_trace_en | output | 1 | Channel-register write trace enable |

## Verification
On every cycle the assertions check several properties. The halt can only rise on a boundary strobe. It holds while an enabled external request is present, and it cannot rise in the cycle after a resume has armed the skip. The clear pulse lasts a single cycle and empties the pending set. Pending requests otherwise stay sticky, and a disabled external request with nothing pending never halts. Other behaviour shows up only in the bench's scenarios. These cover the choice of boundary that the timing bit makes, a clear command leaving an external halt in place, event-out muting, the single-step and forced-instruction exceptions to pin gating, and the register's reserved and self-clearing read values.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_SRC  = 9;
  localparam int B_EXT_EN = 0;
  localparam int B_EXT_TH = 1;
  localparam int B_MUTE   = 2;
  localparam int B_CLR    = 3;
  localparam int B_TSTOP  = 4;
  localparam int B_PSTOP  = 5;
  localparam int B_CHW_N  = 6;
  localparam logic [REG_W-1:0] WR_MASK = 8'b0111_0111;
  localparam logic [NUM_SRC-1:0] EVT_MASK = 9'b1_1111_0000;
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_halt_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl,
  output logic         clr,
  output logic [W-1:0] rdata
);
  logic [W-1:0] ctrl_q, ctrl_d;
  logic         clr_q, clr_d;

  always_comb begin
    ctrl_d = ctrl_q;
    clr_d  = 1'b0;
    if (we) begin
      ctrl_d = wdata & WR_MASK[W-1:0];
      clr_d  = wdata[B_CLR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      clr_q  <= clr_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign clr   = clr_q;
  assign rdata = ctrl_q;

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~WR_MASK[W-1:0]) == '0);
  p_clr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !(we && wdata[B_CLR])) |=> !clr_q);
endmodule

// File: rtl/dbg_req_track.sv
module dbg_req_track
  import dbg_halt_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter logic [N-1:0] EMASK = EVT_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         clr,
  input  logic         ext_q,
  input  logic         dbg_req,
  input  logic         mute,
  output logic         int_any,
  output logic         evt
);
  logic [N-1:0] pend_q, pend_d;
  logic         rflag_q, rflag_d;

  always_comb begin
    if (clr) begin
      pend_d  = '0;
      rflag_d = 1'b0;
    end else begin
      pend_d  = pend_q | req;
      rflag_d = rflag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      rflag_q <= 1'b1;
    end else begin
      pend_q  <= pend_d;
      rflag_q <= rflag_d;
    end
  end

  assign int_any = |pend_q;
  assign evt = !mute && (rflag_q || dbg_req || (|(pend_q & EMASK)) || ext_q);

  p_clr_wipes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pend_q == '0 && !rflag_q));
  p_pend_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/dbg_halt_seq.sv
module dbg_halt_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic uc_end,
  input  logic thr_end,
  input  logic int_any,
  input  logic ext_q,
  input  logic ext_thread,
  input  logic resume,
  output logic halt
);
  logic halt_q, halt_d;
  logic skip_q, skip_d;
  logic hit, release_ok;

  always_comb begin
    hit = (uc_end && (int_any || (ext_q && !ext_thread))) ||
          (thr_end && ext_q && ext_thread);
    release_ok = halt_q && resume && !ext_q;
    halt_d = halt_q;
    skip_d = skip_q;
    if (halt_q) begin
      if (release_ok) begin
        halt_d = 1'b0;
        skip_d = 1'b1;
      end
    end else if (skip_q) begin
      if (uc_end || thr_end) skip_d = 1'b0;
    end else if (hit) begin
      halt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
      skip_q <= skip_d;
    end
  end

  assign halt = halt_q;

  p_hold_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && ext_q) |=> halt_q);
  p_skip_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && !halt_q) |=> !halt_q);
  p_rise_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !uc_end && !thr_end) |=> !halt_q);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [N-1:0] bkpt_req,
  input  logic         ext_req,
  input  logic         dbg_req,
  input  logic         uc_end,
  input  logic         thr_end,
  input  logic         resume,
  input  logic         step_i,
  input  logic         forced_i,
  input  logic         prog_trace_on,
  output logic         halt,
  output logic         tclk_en,
  output logic         pin_smp_en,
  output logic         evt_out,
  output logic         chw_trace_en
);
  logic [1:0]   rsync_q;
  logic         rst_n_s;
  logic [W-1:0] ctrl;
  logic         clr, int_any, ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  dbg_ctrl_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n_s), .we(reg_we), .wdata(reg_wdata),
    .ctrl(ctrl), .clr(clr), .rdata(reg_rdata)
  );

  assign ext_q = ctrl[B_EXT_EN] && ext_req;

  dbg_req_track #(.N(N), .EMASK(EVT_MASK[N-1:0])) u_trk (
    .clk(clk), .rst_n(rst_n_s), .req(bkpt_req), .clr(clr), .ext_q(ext_q),
    .dbg_req(dbg_req), .mute(ctrl[B_MUTE]), .int_any(int_any), .evt(evt_out)
  );

  dbg_halt_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .uc_end(uc_end), .thr_end(thr_end),
    .int_any(int_any), .ext_q(ext_q), .ext_thread(ctrl[B_EXT_TH]),
    .resume(resume), .halt(halt)
  );

  assign tclk_en      = !(halt && ctrl[B_TSTOP]);
  assign pin_smp_en   = !(ctrl[B_PSTOP] && (forced_i || (halt && !step_i)));
  assign chw_trace_en = !ctrl[B_CHW_N] && prog_trace_on;

  p_ext_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ctrl[B_EXT_EN] && !int_any && !halt) |=> !halt);
endmodule

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [8:0] bkpt_req = '0;
  logic ext_req = 0, dbg_req = 0, uc_end = 0, thr_end = 0, resume = 0;
  logic step_i = 0, forced_i = 0, prog_trace_on = 0;
  logic halt, tclk_en, pin_smp_en, evt_out, chw_trace_en;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  dbg_halt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bkpt_req(bkpt_req), .ext_req(ext_req),
    .dbg_req(dbg_req), .uc_end(uc_end), .thr_end(thr_end), .resume(resume),
    .step_i(step_i), .forced_i(forced_i), .prog_trace_on(prog_trace_on),
    .halt(halt), .tclk_en(tclk_en), .pin_smp_en(pin_smp_en),
    .evt_out(evt_out), .chw_trace_en(chw_trace_en)
  );

  localparam logic [15:0] VEC [6] = '{
    {8'hFF, 8'h77}, {8'h08, 8'h00}, {8'h80, 8'h00},
    {8'h41, 8'h41}, {8'h36, 8'h36}, {8'h00, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_uc();
    uc_end = 1'b1; step(); uc_end = 1'b0;
  endtask

  task automatic pulse_thr();
    thr_end = 1'b1; step(); thr_end = 1'b0;
  endtask

  task automatic pulse_res();
    resume = 1'b1; step(); resume = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R12 / R1 reset state
    chk("R1 reset rdata", reg_rdata, 8'h00);
    chk("R12 reset halt", halt, 0);
    chk("R12 reset evt_out", evt_out, 1);
    chk("R9 reset tclk_en", tclk_en, 1);

    // R1 register table
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][15:8]);
      chk("R1 readback", reg_rdata, VEC[i][7:0]);
    end
    chk("R2 reset flag cleared", evt_out, 0);
    dbg_req = 1'b1; step();
    chk("R8 dbg_req on evt", evt_out, 1);
    dbg_req = 1'b0;

    // R3 internal request halts at next microcycle end
    bkpt_req = 9'h020; step(); bkpt_req = '0;
    chk("R3 no halt before strobe", halt, 0);
    chk("R8 software pending evt", evt_out, 1);
    pulse_uc();
    chk("R3 halt on uc_end", halt, 1);
    chk("R9 clock runs", tclk_en, 1);
    wr(8'h10);
    chk("R9 clock stopped", tclk_en, 0);
    wr(8'h20);
    chk("R9 clock back", tclk_en, 1);
    chk("R10 pins gated halted", pin_smp_en, 0);
    step_i = 1'b1; step();
    chk("R10 single step samples", pin_smp_en, 1);
    step_i = 1'b0;

    // R7 skip first strobe after resume
    pulse_res();
    chk("R7 resumed", halt, 0);
    pulse_uc();
    chk("R7 first strobe skipped", halt, 0);
    pulse_uc();
    chk("R3 pending still halts", halt, 1);

    // R2 clear command
    wr(8'h08);
    chk("R2 clear reads 0", reg_rdata, 8'h00);
    step();
    chk("R2 pending cleared evt", evt_out, 0);
    pulse_res(); pulse_uc(); pulse_uc();
    chk("R2 no halt after clear", halt, 0);

    // R10 forced instruction
    wr(8'h20);
    forced_i = 1'b1; step();
    chk("R10 forced gates pins", pin_smp_en, 0);
    forced_i = 1'b0; step();
    chk("R10 running samples", pin_smp_en, 1);

    // R4 external disabled
    wr(8'h00);
    ext_req = 1'b1;
    pulse_uc(); pulse_thr();
    chk("R4 ext ignored halt", halt, 0);
    chk("R4 ext ignored evt", evt_out, 0);

    // R5 timing 0 / R6 refusal
    wr(8'h01);
    chk("R8 ext on evt", evt_out, 1);
    pulse_thr();
    chk("R5 thr_end no halt mode0", halt, 0);
    pulse_uc();
    chk("R5 uc_end halt mode0", halt, 1);
    pulse_res();
    chk("R6 resume refused", halt, 1);
    wr(8'h09); step();
    pulse_res();
    chk("R6 clear keeps ext", halt, 1);
    ext_req = 1'b0;
    pulse_res();
    chk("R6 release on negate", halt, 0);
    pulse_uc();

    // R5 timing 1, R6 release by disable
    ext_req = 1'b1;
    wr(8'h03);
    pulse_uc();
    chk("R5 uc_end no halt mode1", halt, 0);
    pulse_thr();
    chk("R5 thr_end halt mode1", halt, 1);
    wr(8'h02);
    pulse_res();
    chk("R6 release on disable", halt, 0);
    pulse_uc();

    // R8 mute
    wr(8'h07); step();
    chk("R8 muted", evt_out, 0);
    wr(8'h01); step();
    chk("R8 unmuted", evt_out, 1);
    ext_req = 1'b0;

    // R11 channel write trace
    wr(8'h00);
    prog_trace_on = 1'b1; step();
    chk("R11 trace on", chw_trace_en, 1);
    wr(8'h40);
    chk("R11 trace off by bit", chw_trace_en, 0);
    wr(8'h00);
    prog_trace_on = 1'b0; step();
    chk("R11 trace needs program trace", chw_trace_en, 0);

    // R12 reset mid-run
    bkpt_req = 9'h001; step(); bkpt_req = '0;
    pulse_uc();
    chk("R3 data write halts", halt, 1);
    do_reset();
    chk("R12 halt cleared", halt, 0);
    chk("R12 evt after reset", evt_out, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule